// File: doc/BRIEF.md
# Ternary CAM with Shared Mask Pool

This block is a small ternary content-addressable lookup built from registers and gates. Each of its 16 slots holds a stored key, a valid flag, a result payload and a short selector. The selector picks one of 8 mask registers that all slots share. No slot carries a private mask. A search key goes whole to every slot at once. Each slot compares it under the mask it selects. A priority stage then reports the lowest-numbered slot that matched, together with that slot's payload.

A mask bit of one means the key bit must be equal. A mask bit of zero means the key bit is ignored. For longest-prefix routing, software writes the more specific routes into lower slots and the broader routes into higher slots, so the most specific route wins. A single write port loads either a slot or a shared mask. The result is registered, so it appears one cycle after the search.

Top module: `tcam_gmask`

## Requirements
- R1: `res_vld` is high in the cycle after a cycle with `srch_vld` high. It is low in every other cycle.
- R2: A valid slot matches when `((srch_key ^ stored_key) & mask) == 0`. A mask bit of 1 forces that key bit to compare, and a mask bit of 0 makes that key bit don't care.
- R3: Each slot holds a 3-bit selector into the 8 shared masks. Rewriting a shared mask changes the matching of every slot that selects it, without rewriting those slots.
- R4: When several slots match, the result reports only the lowest-numbered one, with its index and its payload.
- R5: A slot whose valid flag is clear never matches. A search that matches no slot returns `res_hit`=0, `res_idx`=0 and `res_data`=0.
- R6: A write affects searches issued in the following cycle and later. A search issued in the same cycle as a write sees the old contents.
- R7: After reset all slots are invalid and all masks are all-ones. `res_vld` and `res_hit` are 0.
- R8: While `srch_vld` is low, `res_hit`, `res_idx` and `res_data` keep their last values.
- R9: Write encoding. With `wr_tgt`=0, `wr_addr` selects a slot, which takes `wr_key`, `wr_msel`, `wr_data` and `wr_valid`. With `wr_tgt`=1, the low 3 bits of `wr_addr` select a mask, which takes `wr_key` as its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| srch_vld | input | 1 | Search request |
| srch_key | input | KEY_W (32) | Key to look up |
| res_vld | output | 1 | Result valid, one cycle after the search |
| res_hit | output | 1 | At least one valid slot matched |
| res_idx | output | IDX_W (4) | Index of the winning slot |
| res_data | output | DATA_W (16) | Payload of the winning slot |
| wr_en | input | 1 | Write strobe |
| wr_tgt | input | 1 | 0 writes a slot, 1 writes a shared mask |
| wr_addr | input | IDX_W (4) | Slot index, or mask index in the low bits |
| wr_key | input | KEY_W (32) | Stored key, or mask value |
| wr_msel | input | MSEL_W (3) | Mask selector for a slot |
| wr_data | input | DATA_W (16) | Payload for a slot |
| wr_valid | input | 1 | Valid flag for a slot |

## Verification
The hardest case to reach from the ports is a write and a search in the same cycle. The search must see the contents from before the write. The bench drives both in one cycle, expects a miss, and then repeats the search to see the new slot win. Another hard case is a shared-mask rewrite that changes the result of a slot that was never touched. The bench widens a mask that a slot already selects and shows that a key which used to miss now hits.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
   typedef enum logic {
      WT_ENTRY = 1'b0,
      WT_MASK  = 1'b1
   } wr_tgt_e;

   function automatic logic masked_eq(input logic [63:0] a,
                                      input logic [63:0] b,
                                      input logic [63:0] m);
      return ((a ^ b) & m) == 64'd0;
   endfunction
endpackage

// File: rtl/tcam_mask_bank.sv
module tcam_mask_bank #(
   parameter int KEY_W = 32,
   parameter int MASKS = 8,
   localparam int MSEL_W = $clog2(MASKS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [MSEL_W-1:0]            waddr,
   input  logic [KEY_W-1:0]             wmask,
   output logic [MASKS-1:0][KEY_W-1:0]  masks
);
   for (genvar m = 0; m < MASKS; m++) begin : g_mask
      always_ff @(posedge clk) begin
         if (!rst_n)
            masks[m] <= '1;
         else if (we && waddr == MSEL_W'(m))
            masks[m] <= wmask;
      end
   end
endmodule

// File: rtl/tcam_entry_array.sv
module tcam_entry_array
   import tcam_pkg::*;
#(
   parameter int KEY_W   = 32,
   parameter int DATA_W  = 16,
   parameter int ENTRIES = 16,
   parameter int MASKS   = 8,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int MSEL_W = $clog2(MASKS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [IDX_W-1:0]              waddr,
   input  logic [KEY_W-1:0]              wkey,
   input  logic [MSEL_W-1:0]             wmsel,
   input  logic [DATA_W-1:0]             wdata,
   input  logic                          wvalid,
   input  logic [KEY_W-1:0]              skey,
   input  logic [MASKS-1:0][KEY_W-1:0]   masks,
   output logic [ENTRIES-1:0]            match,
   output logic [ENTRIES-1:0][DATA_W-1:0] ent_data
);
   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic              vld_q;
      logic [KEY_W-1:0]  key_q;
      logic [MSEL_W-1:0] msel_q;
      logic [DATA_W-1:0] data_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q  <= 1'b0;
            key_q  <= '0;
            msel_q <= '0;
            data_q <= '0;
         end else if (we && waddr == IDX_W'(e)) begin
            vld_q  <= wvalid;
            key_q  <= wkey;
            msel_q <= wmsel;
            data_q <= wdata;
         end
      end

      always_comb begin
         match[e] = vld_q && masked_eq(64'(skey), 64'(key_q), 64'(masks[msel_q]));
      end
      assign ent_data[e] = data_q;
   end
endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
   parameter int N = 16,
   localparam int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   output logic [N-1:0]     gnt,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      gnt = '0;
      any = 1'b0;
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !any) begin
            any    = 1'b1;
            gnt[i] = 1'b1;
            idx    = IDX_W'(i);
         end
      end
   end

   // R4: at most one winner, and only among requesters
   a_r4_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt) && ((gnt & ~req) == '0));
   a_r4_any_iff_req: assert property (@(posedge clk) disable iff (!rst_n)
      any == (gnt != '0));
endmodule

// File: rtl/tcam_gmask.sv
module tcam_gmask
   import tcam_pkg::*;
#(
   parameter int KEY_W   = 32,
   parameter int DATA_W  = 16,
   parameter int ENTRIES = 16,
   parameter int MASKS   = 8,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int MSEL_W = $clog2(MASKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              srch_vld,
   input  logic [KEY_W-1:0]  srch_key,
   output logic              res_vld,
   output logic              res_hit,
   output logic [IDX_W-1:0]  res_idx,
   output logic [DATA_W-1:0] res_data,
   input  logic              wr_en,
   input  logic              wr_tgt,
   input  logic [IDX_W-1:0]  wr_addr,
   input  logic [KEY_W-1:0]  wr_key,
   input  logic [MSEL_W-1:0] wr_msel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_valid
);
   if (ENTRIES < 2 || MASKS < 2) begin : g_chk_size
      $error("tcam_gmask: ENTRIES and MASKS must be at least 2");
   end
   if (MASKS > ENTRIES) begin : g_chk_masks
      $error("tcam_gmask: MASKS may not exceed ENTRIES");
   end
   if (KEY_W > 64 || KEY_W < 1) begin : g_chk_key
      $error("tcam_gmask: KEY_W must be 1..64");
   end

   logic [MASKS-1:0][KEY_W-1:0]    masks;
   logic [ENTRIES-1:0]             match;
   logic [ENTRIES-1:0][DATA_W-1:0] ent_data;
   logic [ENTRIES-1:0]             gnt;
   logic                           any_hit;
   logic [IDX_W-1:0]               win_idx;
   logic                           we_ent, we_msk;

   assign we_ent = wr_en && (wr_tgt == WT_ENTRY);
   assign we_msk = wr_en && (wr_tgt == WT_MASK);

   tcam_mask_bank #(.KEY_W(KEY_W), .MASKS(MASKS)) i_masks (
      .clk(clk), .rst_n(rst_n), .we(we_msk),
      .waddr(wr_addr[MSEL_W-1:0]), .wmask(wr_key), .masks(masks));

   tcam_entry_array #(.KEY_W(KEY_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES),
                      .MASKS(MASKS)) i_entries (
      .clk(clk), .rst_n(rst_n), .we(we_ent), .waddr(wr_addr),
      .wkey(wr_key), .wmsel(wr_msel), .wdata(wr_data), .wvalid(wr_valid),
      .skey(srch_key), .masks(masks), .match(match), .ent_data(ent_data));

   tcam_prio_enc #(.N(ENTRIES)) i_prio (
      .clk(clk), .rst_n(rst_n), .req(match), .gnt(gnt),
      .any(any_hit), .idx(win_idx));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_vld  <= 1'b0;
         res_hit  <= 1'b0;
         res_idx  <= '0;
         res_data <= '0;
      end else begin
         res_vld <= srch_vld;
         if (srch_vld) begin
            res_hit  <= any_hit;
            res_idx  <= any_hit ? win_idx : '0;
            res_data <= any_hit ? ent_data[win_idx] : '0;
         end
      end
   end

   a_r1_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
      srch_vld |=> res_vld);
   a_r1_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !srch_vld |=> !res_vld);
   a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !srch_vld |=> $stable(res_hit) && $stable(res_idx) && $stable(res_data));
   a_r5_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (srch_vld && match == '0) |=> !res_hit && res_idx == '0 && res_data == '0);
endmodule

// File: tb/test_tcam_gmask.sv
module test_tcam_gmask;
   localparam int KEY_W = 32, DATA_W = 16, IDX_W = 4, MSEL_W = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              srch_vld = 1'b0;
   logic [KEY_W-1:0]  srch_key = '0;
   logic              res_vld, res_hit;
   logic [IDX_W-1:0]  res_idx;
   logic [DATA_W-1:0] res_data;
   logic              wr_en = 1'b0, wr_tgt = 1'b0, wr_valid = 1'b0;
   logic [IDX_W-1:0]  wr_addr = '0;
   logic [KEY_W-1:0]  wr_key = '0;
   logic [MSEL_W-1:0] wr_msel = '0;
   logic [DATA_W-1:0] wr_data = '0;

   int checks = 0, errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   tcam_gmask i_tcam_gmask (
      .clk(clk), .rst_n(rst_n), .srch_vld(srch_vld), .srch_key(srch_key),
      .res_vld(res_vld), .res_hit(res_hit), .res_idx(res_idx),
      .res_data(res_data), .wr_en(wr_en), .wr_tgt(wr_tgt),
      .wr_addr(wr_addr), .wr_key(wr_key), .wr_msel(wr_msel),
      .wr_data(wr_data), .wr_valid(wr_valid));

   task automatic chk(string req, longint got, longint exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic wr_entry(int a, logic [31:0] k, int ms, int d, bit v);
      @(negedge clk);
      wr_en = 1; wr_tgt = 0; wr_addr = IDX_W'(a); wr_key = k;
      wr_msel = MSEL_W'(ms); wr_data = DATA_W'(d); wr_valid = v;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic wr_mask(int a, logic [31:0] m);
      @(negedge clk);
      wr_en = 1; wr_tgt = 1; wr_addr = IDX_W'(a); wr_key = m;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic search(logic [31:0] k);
      @(negedge clk);
      srch_vld = 1; srch_key = k;
      @(negedge clk);
      srch_vld = 0;
   endtask

   task automatic expect_res(string req, bit hit, int idx, int d);
      chk({req, " vld"}, res_vld, 1);
      chk({req, " hit"}, res_hit, hit);
      chk({req, " idx"}, res_idx, idx);
      chk({req, " data"}, res_data, d);
   endtask

   task automatic t_reset();
      chk("R7 vld after reset", res_vld, 0);
      chk("R7 hit after reset", res_hit, 0);
      search(32'h0);
      expect_res("R7 R5 empty table miss", 0, 0, 0);
   endtask

   task automatic t_exact();
      wr_entry(3, 32'h0A000001, 0, 16'h0011, 1);
      search(32'h0A000001);
      expect_res("R2 R9 exact hit", 1, 3, 16'h0011);
      search(32'h0A000002);
      expect_res("R2 exact miss", 0, 0, 0);
   endtask

   task automatic t_masked();
      wr_mask(1, 32'hFFFFFFF0);
      wr_entry(5, 32'h0A000010, 1, 16'h0022, 1);
      search(32'h0A00001F);
      expect_res("R2 low bits dont care", 1, 5, 16'h0022);
      search(32'h0A000020);
      expect_res("R2 masked miss", 0, 0, 0);
   endtask

   task automatic t_priority();
      wr_entry(2, 32'h0A000015, 0, 16'h0033, 1);
      search(32'h0A000015);
      expect_res("R4 lower slot wins", 1, 2, 16'h0033);
      search(32'h0A000016);
      expect_res("R4 broader slot", 1, 5, 16'h0022);
   endtask

   task automatic t_invalid();
      wr_entry(2, 32'h0A000015, 0, 16'h0033, 0);
      search(32'h0A000015);
      expect_res("R5 invalid slot skipped", 1, 5, 16'h0022);
   endtask

   task automatic t_shared_mask();
      wr_mask(1, 32'hFFFFFF00);
      search(32'h0A000020);
      expect_res("R3 widened shared mask", 1, 5, 16'h0022);
   endtask

   task automatic t_write_timing();
      @(negedge clk);
      wr_en = 1; wr_tgt = 0; wr_addr = 0; wr_key = 32'hDEAD0000;
      wr_msel = 0; wr_data = 16'h00AA; wr_valid = 1;
      srch_vld = 1; srch_key = 32'hDEAD0000;
      @(negedge clk);
      wr_en = 0; srch_vld = 0;
      expect_res("R6 same cycle sees old", 0, 0, 0);
      search(32'hDEAD0000);
      expect_res("R6 next cycle sees new", 1, 0, 16'h00AA);
   endtask

   task automatic t_hold();
      @(negedge clk);
      chk("R1 vld low when idle", res_vld, 0);
      chk("R8 hit held", res_hit, 1);
      chk("R8 idx held", res_idx, 0);
      chk("R8 data held", res_data, 16'h00AA);
   endtask

   task automatic t_catch_all();
      wr_mask(7, 32'h0);
      wr_entry(15, 32'hFFFFFFFF, 7, 16'hBEEF, 1);
      search(32'h12345678);
      expect_res("R2 R4 all dont care top slot", 1, 15, 16'hBEEF);
      search(32'h0A000015);
      expect_res("R4 catch-all loses", 1, 5, 16'h0022);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_exact();
      t_masked();
      t_priority();
      t_invalid();
      t_shared_mask();
      t_write_timing();
      t_hold();
      t_catch_all();
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule